// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block adds enhanced-mode address and data cycles to the ordinary registers of a host-side parallel port. A host access to the address offset or the data offset starts a handshake with the peripheral, but only when the stored control byte is in the exact state that mode requires. The write state and the read state are different, so software must set the direction and the four signal bits deliberately before any cycle runs. An access that does not meet the gate completes at once and does nothing on the peripheral side.

Every byte moved on the peripheral side is a strobe/wait handshake. A strobe (address or data) stays high until the peripheral raises its wait line, and the next byte starts only after wait falls again. Data-offset accesses may be 1, 2 or 4 bytes wide and are sent least significant byte first. If the peripheral does not answer within a set number of clocks, the strobe is dropped, the remaining bytes are skipped and a sticky timeout flag is set. Software reads that flag in status bit 0 and clears it by writing a 1 there. The host bus is stalled until `ready_o` pulses.

Top module: `epp_gate`

## Requirements
- R1: After reset the control byte reads 0x0C, the timeout flag is 0, `pd_oe_o` is 1, both strobes are low and `pwrite_o` is 1.
- R2: A write to offset 3 or 4 starts a handshake only when (control AND 0x2F) equals 0x04. Otherwise no strobe is raised and the access still completes.
- R3: A read from offset 3 or 4 starts a handshake only when (control AND 0x2F) equals 0x24. Otherwise no strobe is raised and `rdata_o` returns all ones over the access width.
- R4: Offset 3 cycles use `astb_o` and offset 4 cycles use `dstb_o`. `pwrite_o` is 1 for writes and 0 for reads, and it stays constant across every byte of the access.
- R5: `size_i` of 0, 1 or 2 moves 1, 2 or 4 bytes on offset 4, least significant byte first in both directions. Read data is zero-extended. Offset 3 always moves one byte.
- R6: A strobe stays high until `pwait_i` is seen high. It is then dropped, and the next byte starts only after `pwait_i` is seen low.
- R7: A strobe that sees no `pwait_i` within TMO_CYCLES clocks is dropped after exactly TMO_CYCLES clocks. The flag is set, the remaining bytes are skipped, and a read returns all ones over its width. A wait seen in the last allowed clock still counts as success.
- R8: A read of offset 1 returns the timeout flag in bit 0 and zeros elsewhere. A write of offset 1 with bit 0 set clears the flag, and a write with bit 0 clear leaves it unchanged.
- R9: Offset 2 stores and returns the control byte, which drives `ctrl_o`. When a write changes bit 5 (direction), `pd_oe_o` switches one clock before `ctrl_o` takes the new value.
- R10: Each accepted request yields exactly one single-cycle `ready_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request, held until ready_o |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset |
| size_i | input | 2 | Access width: 0 byte, 1 half, 2 word |
| wdata_i | input | HOST_W | Host write data |
| ready_o | output | 1 | Access complete pulse |
| rdata_o | output | HOST_W | Host read data, valid with ready_o |
| ctrl_o | output | 8 | Stored control byte |
| pd_out_o | output | 8 | Peripheral data out |
| pd_in_i | input | 8 | Peripheral data in |
| pd_oe_o | output | 1 | Peripheral data bus output enable |
| astb_o | output | 1 | Address strobe |
| dstb_o | output | 1 | Data strobe |
| pwrite_o | output | 1 | 1 = write cycle, 0 = read cycle |
| pwait_i | input | 1 | Peripheral wait / acknowledge |

## Verification
Two events can land in the same clock: the peripheral's wait can arrive in the very clock the timeout window runs out. The bench's peripheral model can be set to raise wait in any chosen strobe clock. It is set to answer exactly in clock TMO_CYCLES, which must succeed with the flag left clear, and in clock TMO_CYCLES+1, which must abort after one strobe of exactly TMO_CYCLES clocks. The two outcomes are judged from the number of strobes, the width of the last strobe, the returned data and a later status read.

// File: rtl/epp_pkg.sv
package epp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_STB,
        ST_REL,
        ST_DONE
    } epp_state_t;

    localparam logic [2:0] OFS_STATUS = 3'd1;
    localparam logic [2:0] OFS_CTRL   = 3'd2;
    localparam logic [2:0] OFS_EADDR  = 3'd3;
    localparam logic [2:0] OFS_EDATA  = 3'd4;

    // direction bit plus the four signal bits take part in the gate
    localparam logic [7:0] GATE_MASK  = 8'h2F;
    localparam logic [7:0] GATE_WRITE = 8'h04;
    localparam logic [7:0] GATE_READ  = 8'h24;
    localparam logic [7:0] CTRL_RESET = 8'h0C;
    localparam int         DIR_BIT    = 5;
endpackage

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run_i ? cnt_q + TW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == TW'(LIMIT - 1));

    // R7: the owner must leave the strobe state no later than the last allowed clock
    a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < TW'(LIMIT)));
endmodule

// File: rtl/epp_byte_lanes.sv
module epp_byte_lanes #(
    parameter int NB = 4
) (
    input  logic [8*NB-1:0]         word_i,
    input  logic [$clog2(NB)-1:0]   sel_i,
    input  logic [7:0]              byte_i,
    output logic [7:0]              byte_o,
    output logic [8*NB-1:0]         word_o
);
    logic [7:0] lane [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane[g] = word_i[8*g +: 8];
        assign word_o[8*g +: 8] = (sel_i == g) ? byte_i : word_i[8*g +: 8];
    end

    assign byte_o = lane[sel_i];
endmodule

// File: rtl/epp_gate.sv
module epp_gate
    import epp_pkg::*;
#(
    parameter int HOST_W     = 32,
    parameter int TMO_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [1:0]        size_i,
    input  logic [HOST_W-1:0] wdata_i,
    output logic              ready_o,
    output logic [HOST_W-1:0] rdata_o,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        pd_out_o,
    input  logic [7:0]        pd_in_i,
    output logic              pd_oe_o,
    output logic              astb_o,
    output logic              dstb_o,
    output logic              pwrite_o,
    input  logic              pwait_i
);
    localparam int NB = HOST_W / 8;
    localparam int IW = $clog2(NB);

    typedef struct packed {
        epp_state_t         state;
        logic [7:0]         ctrl;
        logic               tmo;
        logic               bus_in;
        logic               pwr;
        logic               wr;
        logic               is_addr;
        logic [IW-1:0]      idx;
        logic [IW-1:0]      last;
        logic [HOST_W-1:0]  wdat;
        logic [HOST_W-1:0]  rdat;
    } regs_t;

    regs_t q, d;

    logic              expired;
    logic [7:0]        lane_byte;
    logic [HOST_W-1:0] lane_word;
    logic [HOST_W-1:0] ones_mask;
    logic              gate_ok;
    logic [IW-1:0]     req_last;

    epp_wait_timer #(.LIMIT(TMO_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (q.state == ST_STB),
        .expired_o(expired)
    );

    epp_byte_lanes #(.NB(NB)) u_lanes (
        .word_i(q.wr ? q.wdat : q.rdat),
        .sel_i (q.idx),
        .byte_i(pd_in_i),
        .byte_o(lane_byte),
        .word_o(lane_word)
    );

    always_comb begin
        ones_mask = '0;
        for (int b = 0; b < NB; b++) begin
            if (b <= int'(q.last)) ones_mask[8*b +: 8] = 8'hFF;
        end
    end

    always_comb begin
        if (addr_i == OFS_EADDR || size_i == 2'd0) req_last = '0;
        else if (size_i == 2'd1)                   req_last = IW'(1);
        else                                       req_last = IW'(NB - 1);
        gate_ok = wr_i ? ((q.ctrl & GATE_MASK) == GATE_WRITE)
                       : ((q.ctrl & GATE_MASK) == GATE_READ);
    end

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_i) begin
                    d.wr      = wr_i;
                    d.wdat    = wdata_i;
                    d.rdat    = '0;
                    d.idx     = '0;
                    d.last    = req_last;
                    d.is_addr = (addr_i == OFS_EADDR);
                    d.state   = ST_DONE;
                    case (addr_i)
                        OFS_STATUS: begin
                            if (wr_i) begin
                                if (wdata_i[0]) d.tmo = 1'b0;
                            end else begin
                                d.rdat = HOST_W'(q.tmo);
                            end
                        end
                        OFS_CTRL: begin
                            if (wr_i) begin
                                if (wdata_i[DIR_BIT] != q.ctrl[DIR_BIT]) begin
                                    d.bus_in = wdata_i[DIR_BIT];
                                    d.state  = ST_TURN;
                                end else begin
                                    d.ctrl = wdata_i[7:0];
                                end
                            end else begin
                                d.rdat = HOST_W'(q.ctrl);
                            end
                        end
                        OFS_EADDR, OFS_EDATA: begin
                            if (gate_ok) begin
                                d.pwr   = wr_i;
                                d.state = ST_STB;
                            end else if (!wr_i) begin
                                for (int b = 0; b < NB; b++) begin
                                    if (b <= int'(req_last)) d.rdat[8*b +: 8] = 8'hFF;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_TURN: begin
                d.ctrl  = q.wdat[7:0];
                d.state = ST_DONE;
            end
            ST_STB: begin
                if (pwait_i) begin
                    if (!q.wr) d.rdat = lane_word;
                    d.state = ST_REL;
                end else if (expired) begin
                    d.tmo   = 1'b1;
                    d.rdat  = q.wr ? '0 : ones_mask;
                    d.state = ST_DONE;
                end
            end
            ST_REL: begin
                if (!pwait_i) begin
                    if (q.idx == q.last) begin
                        d.state = ST_DONE;
                    end else begin
                        d.idx   = q.idx + IW'(1);
                        d.state = ST_STB;
                    end
                end
            end
            ST_DONE: begin
                d.pwr   = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.ctrl    <= CTRL_RESET;
            q.pwr     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready_o  = (q.state == ST_DONE);
    assign rdata_o  = q.rdat;
    assign ctrl_o   = q.ctrl;
    assign pd_out_o = lane_byte;
    assign pd_oe_o  = !q.bus_in;
    assign astb_o   = (q.state == ST_STB) && q.is_addr;
    assign dstb_o   = (q.state == ST_STB) && !q.is_addr;
    assign pwrite_o = q.pwr;

    // R2: a write strobe only ever starts under the write control pattern
    a_r2_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(astb_o || dstb_o) && pwrite_o) |-> ((ctrl_o & GATE_MASK) == GATE_WRITE));

    // R3: a read strobe only ever starts under the read control pattern
    a_r3_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(astb_o || dstb_o) && !pwrite_o) |-> ((ctrl_o & GATE_MASK) == GATE_READ));

    // R4: cycle direction does not move while a strobe is held
    a_r4_pwrite_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((astb_o || dstb_o) && $past(astb_o || dstb_o)) |-> $stable(pwrite_o));

    // R9: bus turnaround never coincides with a control update
    a_r9_turn_first: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pd_oe_o) |-> $stable(ctrl_o));

    // R10: ready is a single-cycle pulse
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    // R8: the flag only clears after a status write with bit 0 set
    a_r8_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.tmo) |-> $past(req_i && wr_i && addr_i == OFS_STATUS && wdata_i[0]));
endmodule

// File: tb/sim_epp_gate.sv
module sim_epp_gate;
    localparam int LIM = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic        ready;
    logic [31:0] rdata;
    logic [7:0]  ctrl, pd_out, pd_in = 8'h00;
    logic        pd_oe, astb, dstb, pwrite, pwait = 1'b0;

    always #2.5 clk = ~clk;

    epp_gate #(.HOST_W(32), .TMO_CYCLES(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .size_i(size), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
        .ctrl_o(ctrl), .pd_out_o(pd_out), .pd_in_i(pd_in), .pd_oe_o(pd_oe),
        .astb_o(astb), .dstb_o(dstb), .pwrite_o(pwrite), .pwait_i(pwait)
    );

    int checks = 0, errors = 0;
    int dly = 1, scnt = 0, wid = 0, nlog = 0, cyc = 0;
    logic [7:0] log_b [8];
    logic       log_a [8];
    logic       log_w [8];

    // peripheral model: raise wait in strobe clock number dly
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (astb || dstb) begin
            if (scnt == 0 && nlog < 8) begin
                log_b[nlog] = pd_out;
                log_a[nlog] = astb;
                log_w[nlog] = pwrite;
                pd_in = 8'hC0 + 8'(nlog);
                nlog = nlog + 1;
            end
            scnt  = scnt + 1;
            wid   = scnt;
            pwait = (scnt >= dly);
        end else begin
            scnt  = 0;
            pwait = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [2:0] a, input logic [1:0] s,
                          input logic [31:0] wd, output logic [31:0] rd);
        int guard = 0;
        @(negedge clk);
        nlog = 0;
        req = 1'b1; wr = w; addr = a; size = s; wdata = wd;
        do begin
            @(negedge clk);
            guard++;
        end while (!ready && guard < 1000);
        if (!ready) begin
            errors++;
            $display("FAIL R10 access hung actual=0 expected=1");
        end
        rd = rdata;
        req = 1'b0;
    endtask

    typedef struct packed {
        logic        w;
        logic [2:0]  a;
        logic [1:0]  s;
        logic [31:0] wd;
        logic [7:0]  dl;
        logic [31:0] ex;
        logic [3:0]  ns;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd3, 2'd0, 32'h5A,       8'd1,   32'h0,        4'd0}, // R2 blocked at reset
        '{1'b0, 3'd4, 2'd2, 32'h0,        8'd1,   32'hFFFFFFFF, 4'd0}, // R3 blocked word
        '{1'b1, 3'd2, 2'd0, 32'h04,       8'd1,   32'h0,        4'd0}, // R9
        '{1'b0, 3'd2, 2'd0, 32'h0,        8'd1,   32'h04,       4'd0}, // R9
        '{1'b1, 3'd3, 2'd0, 32'hA5,       8'd2,   32'h0,        4'd1}, // R2 R4
        '{1'b1, 3'd4, 2'd2, 32'h44332211, 8'd1,   32'h0,        4'd4}, // R5
        '{1'b1, 3'd4, 2'd1, 32'h0000BEEF, 8'd3,   32'h0,        4'd2}, // R5 R6
        '{1'b1, 3'd4, 2'd0, 32'h77,       8'd8,   32'h0,        4'd1}, // R7 last clock
        '{1'b0, 3'd4, 2'd1, 32'h0,        8'd1,   32'h0000FFFF, 4'd0}, // R3 blocked half
        '{1'b0, 3'd1, 2'd0, 32'h0,        8'd1,   32'h0,        4'd0}, // R8
        '{1'b1, 3'd2, 2'd0, 32'h24,       8'd1,   32'h0,        4'd0}, // R9
        '{1'b0, 3'd4, 2'd2, 32'h0,        8'd2,   32'hC3C2C1C0, 4'd4}, // R5 R3
        '{1'b0, 3'd3, 2'd2, 32'h0,        8'd1,   32'h000000C0, 4'd1}, // R4 R5
        '{1'b0, 3'd4, 2'd0, 32'h0,        8'd8,   32'h000000C0, 4'd1}, // R7 last clock
        '{1'b1, 3'd4, 2'd2, 32'h1,        8'd1,   32'h0,        4'd0}, // R2 blocked
        '{1'b0, 3'd4, 2'd1, 32'h0,        8'd9,   32'h0000FFFF, 4'd1}, // R7 timeout
        '{1'b0, 3'd1, 2'd0, 32'h0,        8'd1,   32'h1,        4'd0}, // R8
        '{1'b1, 3'd1, 2'd0, 32'h0,        8'd1,   32'h0,        4'd0}, // R8
        '{1'b0, 3'd1, 2'd0, 32'h0,        8'd1,   32'h1,        4'd0}, // R8 kept
        '{1'b1, 3'd1, 2'd0, 32'h1,        8'd1,   32'h0,        4'd0}, // R8
        '{1'b0, 3'd1, 2'd0, 32'h0,        8'd1,   32'h0,        4'd0}, // R8 cleared
        '{1'b1, 3'd2, 2'd0, 32'h2D,       8'd1,   32'h0,        4'd0}, // R9
        '{1'b0, 3'd4, 2'd0, 32'h0,        8'd1,   32'h000000FF, 4'd0}, // R3 blocked byte
        '{1'b1, 3'd2, 2'd0, 32'h04,       8'd1,   32'h0,        4'd0}, // R9
        '{1'b1, 3'd4, 2'd2, 32'hDDCCBBAA, 8'd255, 32'h0,        4'd1}, // R7 skip rest
        '{1'b0, 3'd1, 2'd0, 32'h0,        8'd1,   32'h1,        4'd0}  // R7 R8
    };

    initial begin
        logic [31:0] rd;
        // watchdog
        fork
            begin
                wait (cyc > 150000);
                errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", 32'(ctrl), 32'h0C);
        chk("R1 oe/strobes/pwrite", {28'h0, pd_oe, astb, dstb, pwrite}, 32'h9);
        rst_n = 1'b1;
        access(1'b0, 3'd1, 2'd0, 32'h0, rd);
        chk("R1 timeout flag", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            dly = int'(VEC[i].dl);
            access(VEC[i].w, VEC[i].a, VEC[i].s, VEC[i].wd, rd);
            chk($sformatf("R2/R3/R7 strobe count vec%0d", i), 32'(nlog), 32'(VEC[i].ns));
            if (!VEC[i].w)
                chk($sformatf("R3/R5/R8 rdata vec%0d", i), rd, VEC[i].ex);
            for (int k = 0; k < nlog && k < 4; k++) begin
                if (VEC[i].w)
                    chk($sformatf("R5 byte order vec%0d b%0d", i, k), 32'(log_b[k]), 32'(VEC[i].wd[8*k +: 8]));
                chk($sformatf("R4 strobe kind vec%0d", i), 32'(log_a[k]), 32'(VEC[i].a == 3'd3));
                chk($sformatf("R4 pwrite vec%0d", i), 32'(log_w[k]), 32'(VEC[i].w));
            end
        end

        // R7: strobe width on timeout and boundary against LIM+1
        access(1'b1, 3'd1, 2'd0, 32'h1, rd);
        dly = LIM + 1;
        access(1'b1, 3'd3, 2'd0, 32'h3C, rd);
        chk("R7 strobe width at timeout", 32'(wid), 32'(LIM));
        access(1'b0, 3'd1, 2'd0, 32'h0, rd);
        chk("R7 flag after LIM+1", rd, 32'h1);
        // R6: wait raised late but in time still completes two bytes
        access(1'b1, 3'd1, 2'd0, 32'h1, rd);
        dly = 5;
        access(1'b1, 3'd4, 2'd1, 32'h00009182, rd);
        chk("R6 two bytes with late wait", 32'(nlog), 32'd2);
        chk("R6 last strobe width", 32'(wid), 32'd5);

        // R9: turnaround precedes control update; R10 single pulse
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 3'd2; size = 2'd0; wdata = 32'h24;
        @(negedge clk);
        chk("R9 oe switched first", 32'(pd_oe), 32'h0);
        chk("R9 ctrl not yet updated", 32'(ctrl), 32'h04);
        @(negedge clk);
        chk("R9 ctrl updated", 32'(ctrl), 32'h24);
        chk("R10 ready asserted", 32'(ready), 32'h1);
        req = 1'b0;
        @(negedge clk);
        chk("R10 ready single cycle", 32'(ready), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule